// File: doc/BRIEF.md
# Bus-to-Network Page Address Translator

This block sits between a local memory bus and the request side of a network interface. A fixed, aligned bridge window is decoded in the bus address space. Only the lower half of that window is translated. It is cut into equal pages, and each page owns one entry in a table that software programs. An entry holds a valid flag, an 8-bit destination node number and a remote page frame number. A bus access that hits a valid entry leaves the block as a network request: the node number plus a 32-bit node-local address, built from the frame number and the untouched in-page offset. The read/write kind of the access travels with it to the packet builder downstream.

An access that falls in the upper half of the window, or that hits an entry marked invalid, is answered with a miss and yields no request. Accesses outside the window get no response at all. Remote data is never cached here, so the block keeps no coherence state. The lookup result is registered, and a table write becomes visible one cycle after its strobe.

The window base, the window size and the page size are parameters. The defaults decode a 64 MiB window with 16 KiB pages, which gives 2048 entries for the 32 MiB translated half.

Top module: `page_xlate_bridge`

## Requirements
- R1: After reset every table entry is invalid and `rsp_valid`, `rsp_hit` and `rsp_miss` are 0; a lookup of any translated page then reports a miss.
- R2: A request whose address lies outside [WIN_BASE, WIN_BASE + 2^WIN_SHIFT) produces no response: `rsp_valid` stays 0 in the following cycle.
- R3: A request inside the window with address bit WIN_SHIFT-1 set (the untranslated upper half) yields `rsp_valid`=1, `rsp_miss`=1 and `rsp_hit`=0, whatever the table holds.
- R4: In the lower half, the page index is address bits [WIN_SHIFT-2:PAGE_SHIFT]. When that entry is valid, the response has `rsp_hit`=1, `rsp_node` equal to the entry's node, and `rsp_addr` equal to {entry frame, address bits [PAGE_SHIFT-1:0]}.
- R5: A lower-half request that selects an invalid entry yields `rsp_miss`=1, `rsp_hit`=0, and `rsp_node` and `rsp_addr` equal to 0.
- R6: The response to a request accepted at a clock edge appears at the next edge and lasts one cycle; with no request, `rsp_valid` is 0.
- R7: `rsp_write` equals the `req_write` strobe of the request it answers (1 = write, 0 = read).
- R8: A table write strobed at an edge is used by lookups from the next edge on; a lookup presented at that same edge still sees the previous entry contents.
- R9: Writing one entry leaves every other entry unchanged.
- R10: Whenever `rsp_valid` is 1, exactly one of `rsp_hit` and `rsp_miss` is 1; when `rsp_valid` is 0, both are 0.
- R11: A table write with `cfg_valid`=0 invalidates the entry, so later lookups of that page miss.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus access presented this cycle |
| req_addr | input | 32 | Local bus byte address |
| req_write | input | 1 | Access kind: 1 write, 0 read |
| cfg_we | input | 1 | Table write strobe |
| cfg_idx | input | WIN_SHIFT-1-PAGE_SHIFT | Entry index to write |
| cfg_valid | input | 1 | Valid flag to store |
| cfg_node | input | 8 | Destination node number to store |
| cfg_frame | input | 32-PAGE_SHIFT | Remote page frame number to store |
| rsp_valid | output | 1 | Response for an in-window access |
| rsp_hit | output | 1 | Translation succeeded; request goes out |
| rsp_miss | output | 1 | Untranslated half or invalid entry |
| rsp_node | output | 8 | Destination node number |
| rsp_addr | output | 32 | Node-local remote address |
| rsp_write | output | 1 | Access kind carried to the packet builder |

## Verification
The bench builds the translator with a 1 KiB window at base 0x8000 and 64-byte pages, so the translated half holds eight entries and the untranslated half another eight pages. At that size every entry can be programmed, read back through lookups at both page edges and in the middle, invalidated and rewritten, and every page of the untranslated half can be probed, along with addresses just outside both window ends. The 26-bit frame field and the 6-bit offset keep the concatenation boundary in reach of arithmetic checks, and the same-edge write-and-lookup collision is driven on a chosen entry.

// File: rtl/xlt_pkg.sv
package xlt_pkg;

    localparam int BUS_AW = 32;
    localparam int NODE_W = 8;
    localparam int REM_AW = 32;

    typedef logic [BUS_AW-1:0] bus_addr_t;
    typedef logic [NODE_W-1:0] node_id_t;
    typedef logic [REM_AW-1:0] rem_addr_t;

    typedef enum logic {
        ACC_READ  = 1'b0,
        ACC_WRITE = 1'b1
    } acc_kind_e;

    typedef enum logic [1:0] {
        REG_OUTSIDE = 2'd0,
        REG_MAPPED  = 2'd1,
        REG_PASSIVE = 2'd2
    } win_region_e;

    typedef struct packed {
        logic      valid;
        logic      hit;
        logic      miss;
        node_id_t  node;
        rem_addr_t addr;
        acc_kind_e kind;
    } xlt_rsp_t;

    function automatic int unsigned entries_for(input int unsigned win_shift,
                                                input int unsigned page_shift);
        return 32'd1 << (win_shift - 1 - page_shift);
    endfunction

    function automatic rem_addr_t join_frame(input rem_addr_t frame_shifted,
                                             input rem_addr_t offset);
        return frame_shifted | offset;
    endfunction

endpackage

// File: rtl/xlt_window_decode.sv
module xlt_window_decode
    import xlt_pkg::*;
#(
    parameter bus_addr_t WIN_BASE   = 32'h4000_0000,
    parameter int        WIN_SHIFT  = 26,
    parameter int        PAGE_SHIFT = 14,
    localparam int       IDX_W      = WIN_SHIFT - 1 - PAGE_SHIFT
) (
    input  bus_addr_t              addr,
    output win_region_e            region,
    output logic [IDX_W-1:0]       page_idx,
    output logic [PAGE_SHIFT-1:0]  page_off
);

    localparam int TAG_W = BUS_AW - WIN_SHIFT;

    logic [TAG_W-1:0] addr_tag;
    logic [TAG_W-1:0] base_tag;
    logic             in_window;
    logic             upper_half;

    assign addr_tag   = addr[BUS_AW-1:WIN_SHIFT];
    assign base_tag   = WIN_BASE[BUS_AW-1:WIN_SHIFT];
    assign in_window  = (addr_tag == base_tag);
    assign upper_half = addr[WIN_SHIFT-1];

    always_comb begin
        if (!in_window) begin
            region = REG_OUTSIDE;
        end else if (upper_half) begin
            region = REG_PASSIVE;
        end else begin
            region = REG_MAPPED;
        end
    end

    assign page_idx = addr[WIN_SHIFT-2:PAGE_SHIFT];
    assign page_off = addr[PAGE_SHIFT-1:0];

endmodule

// File: rtl/xlt_page_table.sv
module xlt_page_table
    import xlt_pkg::*;
#(
    parameter int  IDX_W   = 11,
    parameter int  FRAME_W = 18,
    localparam int ENTRIES = 1 << IDX_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic               wr_vld,
    input  node_id_t           wr_node,
    input  logic [FRAME_W-1:0] wr_frame,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic               rd_vld,
    output node_id_t           rd_node,
    output logic [FRAME_W-1:0] rd_frame
);

    typedef struct packed {
        logic               vld;
        node_id_t           node;
        logic [FRAME_W-1:0] frame;
    } entry_t;

    entry_t tbl_q [ENTRIES];
    entry_t rd_ent;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) begin
                tbl_q[i].vld <= 1'b0;
            end
        end else if (wr_en) begin
            tbl_q[wr_idx] <= '{vld: wr_vld, node: wr_node, frame: wr_frame};
        end
    end

    assign rd_ent   = tbl_q[rd_idx];
    assign rd_vld   = rd_ent.vld;
    assign rd_node  = rd_ent.node;
    assign rd_frame = rd_ent.frame;

    // R8 / R11: a strobed write is held by the selected entry one edge later
    assert_write_lands_R8: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (tbl_q[$past(wr_idx)].vld == $past(wr_vld)))
        else $error("table write did not land in its entry");

    assert_write_node_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_vld) |=> (tbl_q[$past(wr_idx)].node == $past(wr_node)))
        else $error("table write node field not stored");

endmodule

// File: rtl/xlt_resp_stage.sv
module xlt_resp_stage
    import xlt_pkg::*;
#(
    parameter int  PAGE_SHIFT = 14,
    localparam int FRAME_W    = REM_AW - PAGE_SHIFT
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  acc_kind_e             in_kind,
    input  win_region_e           in_region,
    input  logic [PAGE_SHIFT-1:0] in_off,
    input  logic                  ent_vld,
    input  node_id_t              ent_node,
    input  logic [FRAME_W-1:0]    ent_frame,
    output xlt_rsp_t              rsp
);

    xlt_rsp_t  nxt;
    rem_addr_t frame_part;
    rem_addr_t off_part;
    logic      take;
    logic      go;

    assign frame_part = {ent_frame, {PAGE_SHIFT{1'b0}}};
    assign off_part   = {{FRAME_W{1'b0}}, in_off};
    assign take       = in_valid && (in_region != REG_OUTSIDE);
    assign go         = take && (in_region == REG_MAPPED) && ent_vld;

    always_comb begin
        nxt       = '0;
        nxt.kind  = ACC_READ;
        if (take) begin
            nxt.valid = 1'b1;
            nxt.kind  = in_kind;
            nxt.hit   = go;
            nxt.miss  = !go;
            if (go) begin
                nxt.node = ent_node;
                nxt.addr = join_frame(frame_part, off_part);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp      <= '0;
            rsp.kind <= ACC_READ;
        end else begin
            rsp <= nxt;
        end
    end

    // R10: exactly one outcome per response, none without one
    assert_one_outcome_R10: assert property (@(posedge clk) disable iff (rst)
        rsp.valid |-> (rsp.hit != rsp.miss))
        else $error("response without a single outcome");

    assert_quiet_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !rsp.valid |-> (!rsp.hit && !rsp.miss))
        else $error("outcome flag raised without a response");

    // R3: untranslated half always misses
    assert_passive_miss_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_region == REG_PASSIVE) |=> (rsp.miss && !rsp.hit))
        else $error("untranslated half did not miss");

    // R5: invalid entry misses
    assert_invalid_miss_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_region == REG_MAPPED && !ent_vld) |=> (rsp.miss && rsp.addr == '0))
        else $error("invalid entry did not miss cleanly");

    // R4: in-page offset passes through unchanged on a hit
    assert_offset_kept_R4: assert property (@(posedge clk) disable iff (rst)
        rsp.hit |-> (rsp.addr[PAGE_SHIFT-1:0] == $past(in_off)))
        else $error("page offset altered");

    // R7: access kind follows the request
    assert_kind_kept_R7: assert property (@(posedge clk) disable iff (rst)
        rsp.valid |-> (rsp.kind == $past(in_kind)))
        else $error("access kind lost");

endmodule

// File: rtl/page_xlate_bridge.sv
module page_xlate_bridge
    import xlt_pkg::*;
#(
    parameter logic [31:0] WIN_BASE   = 32'h4000_0000,
    parameter int          WIN_SHIFT  = 26,
    parameter int          PAGE_SHIFT = 14,
    localparam int         IDX_W      = WIN_SHIFT - 1 - PAGE_SHIFT,
    localparam int         FRAME_W    = REM_AW - PAGE_SHIFT
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [31:0]        req_addr,
    input  logic               req_write,
    input  logic               cfg_we,
    input  logic [IDX_W-1:0]   cfg_idx,
    input  logic               cfg_valid,
    input  logic [7:0]         cfg_node,
    input  logic [FRAME_W-1:0] cfg_frame,
    output logic               rsp_valid,
    output logic               rsp_hit,
    output logic               rsp_miss,
    output logic [7:0]         rsp_node,
    output logic [31:0]        rsp_addr,
    output logic               rsp_write
);

    win_region_e           region;
    logic [IDX_W-1:0]      page_idx;
    logic [PAGE_SHIFT-1:0] page_off;
    logic                  ent_vld;
    node_id_t              ent_node;
    logic [FRAME_W-1:0]    ent_frame;
    xlt_rsp_t              rsp;
    acc_kind_e             kind;

    assign kind = req_write ? ACC_WRITE : ACC_READ;

    xlt_window_decode #(
        .WIN_BASE   (WIN_BASE),
        .WIN_SHIFT  (WIN_SHIFT),
        .PAGE_SHIFT (PAGE_SHIFT)
    ) u_decode (
        .addr     (req_addr),
        .region   (region),
        .page_idx (page_idx),
        .page_off (page_off)
    );

    xlt_page_table #(
        .IDX_W   (IDX_W),
        .FRAME_W (FRAME_W)
    ) u_table (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (cfg_we),
        .wr_idx   (cfg_idx),
        .wr_vld   (cfg_valid),
        .wr_node  (cfg_node),
        .wr_frame (cfg_frame),
        .rd_idx   (page_idx),
        .rd_vld   (ent_vld),
        .rd_node  (ent_node),
        .rd_frame (ent_frame)
    );

    xlt_resp_stage #(
        .PAGE_SHIFT (PAGE_SHIFT)
    ) u_resp (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (req_valid),
        .in_kind   (kind),
        .in_region (region),
        .in_off    (page_off),
        .ent_vld   (ent_vld),
        .ent_node  (ent_node),
        .ent_frame (ent_frame),
        .rsp       (rsp)
    );

    assign rsp_valid = rsp.valid;
    assign rsp_hit   = rsp.hit;
    assign rsp_miss  = rsp.miss;
    assign rsp_node  = rsp.node;
    assign rsp_addr  = rsp.addr;
    assign rsp_write = (rsp.kind == ACC_WRITE);

    // R6: a response only follows a request one edge earlier
    assert_one_cycle_R6: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(req_valid))
        else $error("response without a request");

    // R2: out-of-window requests produce nothing
    assert_outside_silent_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && region == REG_OUTSIDE) |=> !rsp_valid)
        else $error("response to an out-of-window address");

    // R4: a hit only comes from the translated half
    assert_hit_lower_R4: assert property (@(posedge clk) disable iff (rst)
        rsp_hit |-> !$past(req_addr[WIN_SHIFT-1]))
        else $error("hit from the untranslated half");

endmodule

// File: tb/page_xlate_bridge_tb.sv
module page_xlate_bridge_tb;

    localparam logic [31:0] BASE = 32'h0000_8000;
    localparam int WS   = 10;
    localparam int PS   = 6;
    localparam int IW   = WS - 1 - PS;
    localparam int FW   = 32 - PS;
    localparam int NENT = 1 << IW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [31:0]   req_addr = '0;
    logic          req_write = 1'b0;
    logic          cfg_we = 1'b0;
    logic [IW-1:0] cfg_idx = '0;
    logic          cfg_valid = 1'b0;
    logic [7:0]    cfg_node = '0;
    logic [FW-1:0] cfg_frame = '0;
    logic          rsp_valid, rsp_hit, rsp_miss, rsp_write;
    logic [7:0]    rsp_node;
    logic [31:0]   rsp_addr;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic          m_vld   [NENT];
    logic [7:0]    m_node  [NENT];
    logic [FW-1:0] m_frame [NENT];

    always #4 clk = ~clk;

    page_xlate_bridge #(
        .WIN_BASE   (BASE),
        .WIN_SHIFT  (WS),
        .PAGE_SHIFT (PS)
    ) u_dut (
        .clk (clk), .rst (rst),
        .req_valid (req_valid), .req_addr (req_addr), .req_write (req_write),
        .cfg_we (cfg_we), .cfg_idx (cfg_idx), .cfg_valid (cfg_valid),
        .cfg_node (cfg_node), .cfg_frame (cfg_frame),
        .rsp_valid (rsp_valid), .rsp_hit (rsp_hit), .rsp_miss (rsp_miss),
        .rsp_node (rsp_node), .rsp_addr (rsp_addr), .rsp_write (rsp_write)
    );

    function automatic logic [7:0] node_of(input int i, input int salt);
        return 8'(8'h21 + i * 7 + salt * 13);
    endfunction

    function automatic logic [FW-1:0] frame_of(input int i, input int salt);
        return FW'(32'h0012_3400 + i * 32'h0000_0A5F + salt * 32'h0003_0001);
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tbl_write(input int idx, input logic v, input logic [7:0] nd,
                             input logic [FW-1:0] fr);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = IW'(idx); cfg_valid = v; cfg_node = nd; cfg_frame = fr;
        @(negedge clk);
        cfg_we = 1'b0;
        m_vld[idx] = v; m_node[idx] = nd; m_frame[idx] = fr;
    endtask

    // Lookup of a mapped-half page against the bench model
    task automatic look_mapped(input int pg, input int off, input logic wr, input string tag);
        logic [31:0] a;
        a = BASE + 32'(pg * (1 << PS) + off);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = wr;
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " valid"}, 64'(rsp_valid), 64'd1);
        chk({tag, " hit"},   64'(rsp_hit),   64'(m_vld[pg]));
        chk({tag, " miss"},  64'(rsp_miss),  64'(!m_vld[pg]));
        chk({tag, " node"},  64'(rsp_node),  m_vld[pg] ? 64'(m_node[pg]) : 64'd0);
        chk({tag, " addr"},  64'(rsp_addr),
            m_vld[pg] ? 64'({m_frame[pg], a[PS-1:0]}) : 64'd0);
        chk({tag, " kind R7"}, 64'(rsp_write), 64'(wr));
    endtask

    initial begin
        for (int i = 0; i < NENT; i++) begin
            m_vld[i] = 1'b0; m_node[i] = '0; m_frame[i] = '0;
        end
        repeat (3) @(negedge clk);
        chk("R1 valid after reset", 64'(rsp_valid), 64'd0);
        chk("R1 hit after reset",   64'(rsp_hit),   64'd0);
        chk("R1 miss after reset",  64'(rsp_miss),  64'd0);
        rst = 1'b0;

        // R1 / R5: fresh table misses everywhere
        for (int p = 0; p < NENT; p++) look_mapped(p, p, 1'b0, "R1 R5 empty table");

        // R4 / R7: program all entries, sweep page edges and middle
        for (int p = 0; p < NENT; p++) tbl_write(p, 1'b1, node_of(p, 0), frame_of(p, 0));
        for (int p = 0; p < NENT; p++) begin
            look_mapped(p, 0,           1'b0, "R4 first byte");
            look_mapped(p, 42,          1'b1, "R4 mid byte");
            look_mapped(p, (1<<PS) - 1, 1'b1, "R4 last byte");
        end

        // R3: every untranslated page misses despite a full table
        for (int p = 0; p < NENT; p++) begin
            @(negedge clk);
            req_valid = 1'b1; req_write = p[0];
            req_addr = BASE + 32'((1 << (WS-1)) + p * (1 << PS) + 5);
            @(negedge clk);
            req_valid = 1'b0;
            chk("R3 valid", 64'(rsp_valid), 64'd1);
            chk("R3 miss",  64'(rsp_miss),  64'd1);
            chk("R3 hit",   64'(rsp_hit),   64'd0);
            chk("R3 R7 kind", 64'(rsp_write), 64'(p[0]));
        end

        // R2: addresses just outside both ends and far away
        begin
            logic [31:0] outs [4];
            outs[0] = BASE - 32'd1;
            outs[1] = BASE + 32'(1 << WS);
            outs[2] = 32'hFFFF_FFFF;
            outs[3] = 32'h0000_0000;
            for (int k = 0; k < 4; k++) begin
                @(negedge clk);
                req_valid = 1'b1; req_addr = outs[k]; req_write = 1'b1;
                @(negedge clk);
                req_valid = 1'b0;
                chk("R2 outside no response", 64'(rsp_valid), 64'd0);
                chk("R2 outside no hit",      64'(rsp_hit),   64'd0);
            end
        end

        // R6: response lasts exactly one cycle
        look_mapped(3, 7, 1'b0, "R6 lookup");
        @(negedge clk);
        chk("R6 one cycle only", 64'(rsp_valid), 64'd0);

        // R11 / R9: invalidate one entry, neighbours unaffected
        tbl_write(5, 1'b0, 8'hEE, '1);
        look_mapped(5, 9, 1'b0, "R11 invalidated");
        for (int p = 0; p < NENT; p++) look_mapped(p, 17, 1'b0, "R9 neighbours");

        // R8: write and lookup on the same edge
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = IW'(2); cfg_valid = 1'b1;
        cfg_node = node_of(2, 1); cfg_frame = frame_of(2, 1);
        req_valid = 1'b1; req_addr = BASE + 32'(2 * (1 << PS) + 3); req_write = 1'b0;
        @(negedge clk);
        cfg_we = 1'b0; req_valid = 1'b0;
        chk("R8 same edge old node", 64'(rsp_node), 64'(m_node[2]));
        chk("R8 same edge old addr", 64'(rsp_addr), 64'({m_frame[2], 6'd3}));
        m_node[2] = node_of(2, 1); m_frame[2] = frame_of(2, 1);
        look_mapped(2, 3, 1'b0, "R8 next edge new entry");

        // R8 / R11: revalidate the invalidated entry with new content
        tbl_write(5, 1'b1, node_of(5, 2), frame_of(5, 2));
        look_mapped(5, 63, 1'b1, "R8 revalidated");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule